// File: doc/BRIEF.md
# Boot Memory Source Selector

This block steers the 13-bit address space of a small 8-bit microcontroller between an on-chip mask ROM and an off-chip memory bus. A strap pin is captured while reset is held and decides where code comes from when execution begins. With the strap high, the upper window of the address space, which includes the reset vector, is served by the internal ROM. With the strap low, the same window is served by the external bus.

After reset, the strap pin is ignored. The only way to change the source is a one-way switch. Any read or write to a hidden test location sets a sticky internal-ROM mode bit. The bit can be cleared only by the next reset, which lets code running from external memory hand control over to the internal ROM. The lower part of the map, which holds RAM and I/O handled elsewhere, always goes to the external bus. A small reserved test area is never forwarded anywhere.

Top module: `boot_src_sel`

## Requirements
- R1: While `rst` is high, the mode bit follows `strap` at each clock edge. After reset is released, a read in the ROM window (0x0140 to 0x1FFF) goes to internal ROM if the captured strap was 1, and to the external bus if it was 0.
- R2: Changing `strap` while `rst` is low has no effect on routing.
- R3: A read or a write to address 0x001F sets the mode to internal ROM. The value on `wdata` has no influence.
- R4: Once set, internal-ROM mode stays set until the next reset.
- R5: The switch takes effect for the access in the clock cycle after the 0x001F access. The 0x001F access itself is decoded with the previous mode.
- R6: In internal mode, a read in 0x0140 to 0x1FFF asserts `rom_en`. It does not assert `ext_ce`, and `rdata` equals `rom_rdata`.
- R7: Reads of the reset vector bytes at 0x1FFE and 0x1FFF come from the source chosen by the current mode.
- R8: Accesses to 0x0013 to 0x001F assert neither enable, and reads there return 0x00.
- R9: A read or write below 0x0140 that is outside 0x0013 to 0x001F asserts `ext_ce` in either mode. For such reads, `rdata` equals `ext_rdata`.
- R10: `ext_ce` and `rom_en` are never high together. Neither enable is high while `rst` is high or when there is no read or write strobe. Whenever no source is selected for a read, `rdata` is 0x00.
- R11: A write in the ROM window asserts `ext_ce` in external mode, and asserts neither enable in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap captured while high |
| strap | input | 1 | Boot source strap, 1 selects internal ROM |
| addr | input | 13 | CPU address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | CPU write data (only observed for the hidden address, and ignored) |
| rom_rdata | input | 8 | Read data from internal ROM |
| ext_rdata | input | 8 | Read data from external bus |
| rdata | output | 8 | Selected read data to the CPU |
| ext_ce | output | 1 | External bus chip enable |
| rom_en | output | 1 | Internal ROM enable |

## Verification
A hidden-address access and the mode change it causes fall in adjacent cycles. The mode register updates at the same edge that ends the 0x001F access. The bench places a ROM-window read in the very next cycle and checks that this read, and no earlier one, moves to the internal ROM. Strap toggles after reset, together with repeated hidden accesses carrying different write data, check that only reset and the hidden address move the mode.

// File: rtl/boot_src_sel_pkg.sv
package boot_src_sel_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_ROM  = 2'd2
    } src_t;

    typedef enum logic [1:0] {
        ZONE_LOW  = 2'd0,
        ZONE_TEST = 2'd1,
        ZONE_WIN  = 2'd2
    } zone_t;

    typedef struct packed {
        src_t src;
        logic ext_ce;
        logic rom_en;
    } route_t;

    function automatic zone_t classify(input int unsigned a,
                                       input int unsigned test_lo,
                                       input int unsigned test_hi,
                                       input int unsigned win_base);
        if (a >= test_lo && a <= test_hi) return ZONE_TEST;
        if (a >= win_base)                return ZONE_WIN;
        return ZONE_LOW;
    endfunction

endpackage

// File: rtl/boot_mode_reg.sv
module boot_mode_reg #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int HIDDEN = 'h1F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              internal
);
    localparam logic [ADDR_W-1:0] HID_ADDR = ADDR_W'(HIDDEN);

    logic mode_q;
    logic hit;

    assign hit      = (rd || wr) && (addr == HID_ADDR);
    assign internal = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= strap;
        end else if (hit) begin
            mode_q <= 1'b1;
        end
    end

    assert_strap_capture_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == $past(strap)));

    assert_force_zero_data_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == HID_ADDR && wdata == '0) |=> mode_q);

    assert_force_other_data_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == HID_ADDR && wdata != '0) |=> mode_q);

    assert_force_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == HID_ADDR) |=> mode_q);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        mode_q |=> mode_q);

    assert_strap_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit)) |-> $stable(mode_q));

endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
    import boot_src_sel_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int TEST_LO  = 'h13,
    parameter int TEST_HI  = 'h1F,
    parameter int WIN_BASE = 'h140
) (
    input  logic              active,
    input  logic              internal,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output route_t            route
);
    zone_t zone;
    logic  access;

    assign zone   = classify(32'(addr), TEST_LO, TEST_HI, WIN_BASE);
    assign access = active && (rd || wr);

    always_comb begin
        route = '{src: SRC_NONE, ext_ce: 1'b0, rom_en: 1'b0};
        if (access) begin
            unique case (zone)
                ZONE_LOW: route.ext_ce = 1'b1;
                ZONE_TEST: ;
                ZONE_WIN: begin
                    if (internal) route.rom_en = rd;
                    else          route.ext_ce = 1'b1;
                end
                default: ;
            endcase
        end
        if (rd && route.rom_en)      route.src = SRC_ROM;
        else if (rd && route.ext_ce) route.src = SRC_EXT;
    end

endmodule

// File: rtl/boot_data_mux.sv
module boot_data_mux
    import boot_src_sel_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  src_t              src,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        unique case (src)
            SRC_ROM: rdata = rom_rdata;
            SRC_EXT: rdata = ext_rdata;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/boot_src_sel.sv
module boot_src_sel
    import boot_src_sel_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int TEST_LO  = 'h13,
    parameter int TEST_HI  = 'h1F,
    parameter int HIDDEN   = 'h1F,
    parameter int WIN_BASE = 'h140
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ext_ce,
    output logic              rom_en
);
    localparam logic [ADDR_W-1:0] TLO  = ADDR_W'(TEST_LO);
    localparam logic [ADDR_W-1:0] THI  = ADDR_W'(TEST_HI);
    localparam logic [ADDR_W-1:0] WBAS = ADDR_W'(WIN_BASE);

    logic   internal;
    route_t route;

    boot_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIDDEN(HIDDEN)) u_mode (
        .clk(clk), .rst(rst), .strap(strap), .addr(addr),
        .rd(rd), .wr(wr), .wdata(wdata), .internal(internal)
    );

    boot_addr_decode #(.ADDR_W(ADDR_W), .TEST_LO(TEST_LO), .TEST_HI(TEST_HI),
                       .WIN_BASE(WIN_BASE)) u_dec (
        .active(!rst), .internal(internal), .addr(addr),
        .rd(rd), .wr(wr), .route(route)
    );

    boot_data_mux #(.DATA_W(DATA_W)) u_mux (
        .src(route.src), .rom_rdata(rom_rdata), .ext_rdata(ext_rdata), .rdata(rdata)
    );

    assign ext_ce = route.ext_ce;
    assign rom_en = route.rom_en;

    assert_enables_exclusive_R10: assert property (@(posedge clk)
        !(ext_ce && rom_en));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> (!ext_ce && !rom_en));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!rd && !wr) |-> (!ext_ce && !rom_en && rdata == '0));

    assert_test_area_R8: assert property (@(posedge clk) disable iff (rst)
        (addr >= TLO && addr <= THI) |-> (!ext_ce && !rom_en && rdata == '0));

    assert_low_external_R9: assert property (@(posedge clk) disable iff (rst)
        ((rd || wr) && addr < WBAS && !(addr >= TLO && addr <= THI)) |-> (ext_ce && !rom_en));

    assert_rom_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && rom_en) |-> (rdata == rom_rdata));

    assert_switch_next_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(rd || wr) && $past(addr) == THI && rd && addr >= WBAS) |-> rom_en);

endmodule

// File: tb/boot_src_sel_test.sv
`timescale 1ns/1ps
module boot_src_sel_test;
    logic        clk = 1'b0;
    logic        rst, strap, rd, wr;
    logic [12:0] addr;
    logic [7:0]  wdata, rom_rdata, ext_rdata, rdata;
    logic        ext_ce, rom_en;

    int checks = 0;
    int errors = 0;
    int ref_mode = 0;

    always #4 clk = ~clk;

    assign rom_rdata = addr[7:0] ^ 8'hA5;
    assign ext_rdata = addr[7:0] ^ 8'h3C;

    boot_src_sel uut (
        .clk(clk), .rst(rst), .strap(strap), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rom_rdata(rom_rdata), .ext_rdata(ext_rdata),
        .rdata(rdata), .ext_ce(ext_ce), .rom_en(rom_en)
    );

    task automatic compare(input string tag);
        int a;
        logic e_ext, e_rom;
        logic [7:0] e_data;
        a = int'(addr);
        e_ext = 1'b0; e_rom = 1'b0; e_data = 8'h00;
        if (rst || !(rd || wr)) begin
        end else if (a >= 'h13 && a <= 'h1F) begin
        end else if (a < 'h140 || ref_mode == 0) begin
            e_ext = 1'b1;
            if (rd) e_data = ext_rdata;
        end else if (rd) begin
            e_rom  = 1'b1;
            e_data = rom_rdata;
        end
        checks++;
        if (ext_ce !== e_ext || rom_en !== e_rom || rdata !== e_data) begin
            errors++;
            $display("FAIL %s addr=%h: got ext_ce=%b rom_en=%b rdata=%h, expected %b %b %h",
                     tag, addr, ext_ce, rom_en, rdata, e_ext, e_rom, e_data);
        end
    endtask

    task automatic cyc(input logic r, input logic rdv, input logic wrv,
                       input int a, input logic [7:0] d, input string tag);
        @(negedge clk);
        rst = r; rd = rdv; wr = wrv; addr = 13'(a); wdata = d;
        #2 compare(tag);
        @(posedge clk);
        if (rst) ref_mode = int'(strap);
        else if ((rd || wr) && a == 'h1F) ref_mode = 1;
    endtask

    task automatic do_reset(input logic s);
        strap = s;
        cyc(1, 1, 0, 'h1FFE, 8'h00, "R10 reset quiet");
        cyc(1, 0, 0, 'h0000, 8'h00, "R10 reset quiet");
        cyc(1, 1, 1, 'h0150, 8'h00, "R10 reset quiet");
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; strap = 0; rd = 0; wr = 0; addr = '0; wdata = '0;
        do_reset(0);
        cyc(0, 1, 0, 'h1FFE, 8'h00, "R7 vector hi external");
        cyc(0, 1, 0, 'h1FFF, 8'h00, "R7 vector lo external");
        cyc(0, 1, 0, 'h0200, 8'h00, "R1 strap low external");
        cyc(0, 0, 1, 'h0300, 8'h55, "R11 write external mode");
        strap = 1;
        cyc(0, 1, 0, 'h1000, 8'h00, "R2 strap ignored after reset");
        cyc(0, 1, 0, 'h0050, 8'h00, "R9 low area external");
        cyc(0, 1, 0, 'h0015, 8'h00, "R8 test area read zero");
        cyc(0, 0, 1, 'h0013, 8'h77, "R8 test area write quiet");
        cyc(0, 0, 0, 'h0140, 8'h00, "R10 idle quiet");
        cyc(0, 0, 1, 'h001F, 8'h00, "R3 hidden write");
        cyc(0, 1, 0, 'h0140, 8'h00, "R5 next cycle internal");
        cyc(0, 1, 0, 'h013F, 8'h00, "R9 below window external");
        cyc(0, 0, 1, 'h1500, 8'h9A, "R11 write internal mode quiet");
        cyc(0, 1, 0, 'h001F, 8'h00, "R8 hidden read zero");
        strap = 0;
        cyc(0, 1, 0, 'h1FFF, 8'h00, "R4 sticky internal");
        cyc(0, 1, 0, 'h0800, 8'h00, "R6 internal window read");

        do_reset(0);
        cyc(0, 1, 0, 'h0140, 8'h00, "R1 reset restores external");
        cyc(0, 1, 0, 'h001F, 8'hEE, "R3 hidden read forces");
        cyc(0, 1, 0, 'h1FFF, 8'h00, "R3 forced by read");

        do_reset(0);
        cyc(0, 0, 1, 'h001F, 8'hFF, "R3 hidden write nonzero data");
        cyc(0, 1, 0, 'h1FFE, 8'h00, "R5 R7 vector internal after switch");

        do_reset(1);
        cyc(0, 1, 0, 'h1FFE, 8'h00, "R7 vector hi internal");
        cyc(0, 1, 0, 'h1FFF, 8'h00, "R7 vector lo internal");
        cyc(0, 1, 0, 'h0140, 8'h00, "R1 strap high internal");
        cyc(0, 1, 0, 'h0012, 8'h00, "R9 just below test area");
        cyc(0, 1, 0, 'h0020, 8'h00, "R9 just above test area");
        for (int i = 0; i < 40; i++) begin
            cyc(0, 1'(i % 3 != 2), 1'(i % 3 == 2), (i * 211) % 8192, 8'(i), "R6 R9 R10 sweep");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule